// File: doc/BRIEF.md
# DMA Channel Trigger-Word Detector

This block decides when a quick-DMA channel should start. Each channel owns a mapping register. The register names one parameter set in an external parameter memory, and one of the eight 32-bit words inside that set as the channel's trigger word. The block does not hold the parameter memory. It snoops that memory's write port, which carries a byte address and a write enable.

When a write lands on a channel's trigger word, the block emits a one-clock transfer-request pulse for that channel. Writes to the other seven words of the set leave the channel idle. Software therefore fills in a set in any order and starts the transfer by writing its chosen trigger word last.

The outputs are a per-channel event vector, an any-event flag and the index of the lowest-numbered firing channel. The channel count and the number of parameter sets present are parameters.

Top module: `dma_trigword_detect`

## Requirements
- R1: After reset every mapping register reads 0, which selects set 0 and word 0. The event outputs are 0 until the first qualifying write.
- R2: A mapping register stores write data bits 13:5 as the set index and bits 4:2 as the trigger-word select. Bits 31:14 and 1:0 read as zero whatever is written. A read of a channel number at or above the channel count returns zero.
- R3: A parameter-memory write with `pm_we` high is a qualifying write for a channel when both of these hold: `pm_addr[13:5]` equals the channel's set index, and `pm_addr[4:2]` equals its trigger-word select. The channel's bit in `evt_vec` is then high for exactly the one cycle after that write's clock edge.
- R4: A write to any other word of the mapped set gives no event. A matching address with `pm_we` low also gives no event.
- R5: Every channel whose mapping matches the same write fires in the same cycle. `evt_idx` gives the lowest-numbered firing channel.
- R6: A mapping write and a parameter write in the same cycle are judged against the old mapping. The new mapping applies from the next cycle on.
- R7: A write whose set index is at or above `NUM_SETS` never raises an event, even when a mapping register holds that same index. Set `NUM_SETS-1` still works normally.
- R8: Byte-offset bits `pm_addr[1:0]` take no part in the match.
- R9: `evt_any` is high exactly when `evt_vec` is nonzero. `evt_idx` is 0 when no channel fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mapping register write strobe |
| cfg_addr | input | CH_IDX_W | Channel number for mapping read/write |
| cfg_wdata | input | 32 | Mapping register write data |
| cfg_rdata | output | 32 | Mapping register contents for `cfg_addr` (combinational) |
| pm_we | input | 1 | Snooped parameter-memory write enable |
| pm_addr | input | 14 | Snooped parameter-memory byte address |
| evt_vec | output | NUM_CH | One-cycle transfer-request pulse per channel |
| evt_any | output | 1 | High when any channel fires |
| evt_idx | output | CH_IDX_W | Lowest-numbered firing channel |

## Verification
The match is tried under several write patterns:
- Writes to the trigger word with various byte offsets. These separate a correct word decode from one that also compares byte-offset bits.
- Writes to every non-trigger word of a mapped set, and matching addresses with the enable low. These tell whether the word compare or the enable is dropped.
- Shared mappings. These tell apart a multi-hit vector from a one-hot one, and a lowest-first encoder from a highest-first one.
- A remap that coincides with a parameter write, followed by writes to the old and new targets. This pins down which mapping is in force in each cycle.
- Mappings to set `NUM_SETS-1` and to an index past the end. These check the range limit on both sides.

// File: rtl/dtw_pkg.sv
package dtw_pkg;

    localparam int unsigned SET_W   = 9;
    localparam int unsigned WORD_W  = 3;
    localparam int unsigned PM_AW   = 14;
    localparam int unsigned REG_W   = 32;
    localparam int unsigned MAX_SETS = 1 << SET_W;

    typedef struct packed {
        logic [SET_W-1:0]  set_idx;
        logic [WORD_W-1:0] word_sel;
    } chmap_t;

    typedef struct packed {
        logic [SET_W-1:0]  set_idx;
        logic [WORD_W-1:0] word_idx;
        logic [1:0]        byte_off;
    } pm_addr_t;

    function automatic chmap_t map_from_word(input logic [REG_W-1:0] d);
        chmap_t m;
        m.set_idx  = d[13:5];
        m.word_sel = d[4:2];
        return m;
    endfunction

    function automatic logic [REG_W-1:0] map_to_word(input chmap_t m);
        return {18'b0, m.set_idx, m.word_sel, 2'b00};
    endfunction

endpackage

// File: rtl/dtw_map_bank.sv
module dtw_map_bank
    import dtw_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         addr,
    input  logic [REG_W-1:0]         wdata,
    output logic [REG_W-1:0]         rdata,
    output chmap_t [NUM_CH-1:0]      map_o
);

    chmap_t [NUM_CH-1:0] map_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                map_q[c] <= '0;
            end else if (wr_en && (int'(addr) == c)) begin
                map_q[c] <= map_from_word(wdata);
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(addr) < NUM_CH) begin
            rdata = map_to_word(map_q[addr]);
        end
    end

    assign map_o = map_q;

endmodule

// File: rtl/dtw_chan_match.sv
module dtw_chan_match
    import dtw_pkg::*;
#(
    parameter int unsigned NUM_CH   = 8,
    parameter int unsigned NUM_SETS = 128
) (
    input  logic                 pm_we,
    input  pm_addr_t             pm_addr,
    input  chmap_t [NUM_CH-1:0]  map_i,
    output logic [NUM_CH-1:0]    hit
);

    logic set_in_range;

    assign set_in_range = (int'(pm_addr.set_idx) < NUM_SETS);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
        assign hit[c] = pm_we && set_in_range
                        && (pm_addr.set_idx  == map_i[c].set_idx)
                        && (pm_addr.word_idx == map_i[c].word_sel);
    end

endmodule

// File: rtl/dtw_evt_encoder.sv
module dtw_evt_encoder #(
    parameter int unsigned NUM_CH = 8,
    localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] hit,
    output logic [NUM_CH-1:0] evt_vec,
    output logic              evt_any,
    output logic [IDX_W-1:0]  evt_idx
);

    logic [IDX_W-1:0] first_d;

    always_comb begin
        first_d = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (hit[i]) begin
                first_d = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_vec <= '0;
            evt_any <= 1'b0;
            evt_idx <= '0;
        end else begin
            evt_vec <= hit;
            evt_any <= |hit;
            evt_idx <= first_d;
        end
    end

endmodule

// File: rtl/dma_trigword_detect.sv
module dma_trigword_detect
    import dtw_pkg::*;
#(
    parameter int unsigned NUM_CH   = 8,
    parameter int unsigned NUM_SETS = 128,
    localparam int unsigned CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CH_IDX_W-1:0]  cfg_addr,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    input  logic                 pm_we,
    input  logic [13:0]          pm_addr,
    output logic [NUM_CH-1:0]    evt_vec,
    output logic                 evt_any,
    output logic [CH_IDX_W-1:0]  evt_idx
);

    chmap_t [NUM_CH-1:0] map_w;
    logic   [NUM_CH-1:0] hit_w;
    pm_addr_t            pm_dec;

    assign pm_dec = pm_addr_t'(pm_addr);

    dtw_map_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .map_o (map_w)
    );

    dtw_chan_match #(.NUM_CH(NUM_CH), .NUM_SETS(NUM_SETS)) u_match (
        .pm_we   (pm_we),
        .pm_addr (pm_dec),
        .map_i   (map_w),
        .hit     (hit_w)
    );

    dtw_evt_encoder #(.NUM_CH(NUM_CH)) u_enc (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit_w),
        .evt_vec (evt_vec),
        .evt_any (evt_any),
        .evt_idx (evt_idx)
    );

endmodule

// File: rtl/dtw_chk.sv
module dtw_chk #(
    parameter int unsigned NUM_CH   = 8,
    parameter int unsigned NUM_SETS = 128,
    localparam int unsigned CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic                clk,
    input logic                rst,
    input logic                pm_we,
    input logic [13:0]         pm_addr,
    input logic [31:0]         cfg_rdata,
    input logic [NUM_CH-1:0]   evt_vec,
    input logic                evt_any,
    input logic [CH_IDX_W-1:0] evt_idx
);

    p_rst_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (evt_vec == '0 && !evt_any && evt_idx == '0));

    p_rsv_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[31:14] == '0 && cfg_rdata[1:0] == 2'b00));

    p_no_we_r4: assert property (@(posedge clk) disable iff (rst)
        !pm_we |=> (evt_vec == '0));

    p_lowest_r5: assert property (@(posedge clk) disable iff (rst)
        evt_any |-> (evt_vec[evt_idx]
            && ((evt_vec & ((NUM_CH'(1) << evt_idx) - NUM_CH'(1))) == '0)));

    p_range_r7: assert property (@(posedge clk) disable iff (rst)
        (pm_we && (int'(pm_addr[13:5]) >= NUM_SETS)) |=> (evt_vec == '0));

    p_any_r9: assert property (@(posedge clk) disable iff (rst)
        (evt_any == (evt_vec != '0)) && (evt_any || evt_idx == '0));

endmodule

bind dma_trigword_detect dtw_chk #(.NUM_CH(NUM_CH), .NUM_SETS(NUM_SETS)) u_dtw_chk (
    .clk       (clk),
    .rst       (rst),
    .pm_we     (pm_we),
    .pm_addr   (pm_addr),
    .cfg_rdata (cfg_rdata),
    .evt_vec   (evt_vec),
    .evt_any   (evt_any),
    .evt_idx   (evt_idx)
);

// File: tb/test_dma_trigword_detect.sv
module test_dma_trigword_detect;

    localparam int NCH   = 8;
    localparam int NSETS = 128;
    localparam int IW    = 3;

    typedef struct {
        logic [NCH-1:0] vec;
        logic           any;
        logic [IW-1:0]  idx;
        string          tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_we = 1'b0;
    logic [IW-1:0]   cfg_addr = '0;
    logic [31:0]     cfg_wdata = '0;
    logic [31:0]     cfg_rdata;
    logic            pm_we = 1'b0;
    logic [13:0]     pm_addr = '0;
    logic [NCH-1:0]  evt_vec;
    logic            evt_any;
    logic [IW-1:0]   evt_idx;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    exp_t sb_q[$];
    logic [31:0] mdl [NCH];

    always #10 clk = ~clk;

    dma_trigword_detect #(.NUM_CH(NCH), .NUM_SETS(NSETS)) i_dma_trigword_detect (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pm_we(pm_we),
        .pm_addr(pm_addr), .evt_vec(evt_vec), .evt_any(evt_any), .evt_idx(evt_idx)
    );

    function automatic logic [13:0] pa(int set, int word, int boff);
        return {9'(set), 3'(word), 2'(boff)};
    endfunction

    function automatic logic [31:0] mp(int set, int word);
        return {18'b0, 9'(set), 3'(word), 2'b00};
    endfunction

    // Driver: sets one cycle of inputs and pushes the expected outputs for it.
    task automatic step(input bit cwe, input int ch, input logic [31:0] cd,
                        input bit pwe, input logic [13:0] a, input string tag);
        exp_t e;
        @(negedge clk);
        cfg_we = cwe; cfg_addr = IW'(ch); cfg_wdata = cd;
        pm_we = pwe; pm_addr = a;
        e.vec = '0; e.any = 1'b0; e.idx = '0; e.tag = tag;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (pwe && int'(a[13:5]) < NSETS && a[13:5] == mdl[c][13:5]
                && a[4:2] == mdl[c][4:2]) begin
                e.vec[c] = 1'b1; e.any = 1'b1; e.idx = IW'(c);
            end
        end
        sb_q.push_back(e);
        if (cwe && ch < NCH) mdl[ch] = cd & 32'h0000_3FFC;
    endtask

    task automatic wmap(input int ch, input int set, input int word);
        step(1'b1, ch, mp(set, word), 1'b0, '0, "R2");
    endtask

    task automatic pw(input logic [13:0] a, input string tag);
        step(1'b0, 0, '0, 1'b1, a, tag);
    endtask

    task automatic rd_check(input int ch, input logic [31:0] exp, input string tag);
        step(1'b0, ch, '0, 1'b0, '0, tag);
        #1;
        n_checks++;
        if (cfg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: map read ch%0d actual %h expected %h", tag, ch, cfg_rdata, exp);
        end
    endtask

    // Monitor: compares registered outputs after each rising edge.
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            n_checks++;
            if (evt_vec !== e.vec || evt_any !== e.any || evt_idx !== e.idx) begin
                n_fail++;
                $display("FAIL %s: vec/any/idx actual %b/%b/%0d expected %b/%b/%0d",
                         e.tag, evt_vec, evt_any, evt_idx, e.vec, e.any, e.idx);
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) mdl[c] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        n_checks++;
        if (evt_vec !== '0 || evt_any !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: events after reset actual %b expected 0", evt_vec);
        end
        for (int c = 0; c < NCH; c++) rd_check(c, 32'h0, "R1");
        pw(pa(0, 0, 0), "R1");                 // all channels on set 0 word 0 fire
        pw(pa(0, 1, 0), "R4");
        // R2: field storage and reserved bits
        step(1'b1, 3, 32'hFFFF_FFFF, 1'b0, '0, "R2");
        rd_check(3, 32'h0000_3FFC, "R2");
        // program distinct mappings
        for (int c = 0; c < NCH; c++) wmap(c, 10 + c, c);
        for (int c = 0; c < NCH; c++) rd_check(c, mp(10 + c, c), "R2");
        // R3: each channel fires alone; back-to-back pulses
        for (int c = 0; c < NCH; c++) pw(pa(10 + c, c, 0), "R3");
        pw(pa(13, 3, 0), "R3");
        pw(pa(13, 3, 0), "R3");
        step(1'b0, 0, '0, 1'b0, '0, "R3");
        // R4: other words of a mapped set, and enable low
        for (int w = 0; w < 8; w++) if (w != 5) pw(pa(15, w, 0), "R4");
        step(1'b0, 0, '0, 1'b0, pa(15, 5, 0), "R4");
        // R8: byte offset ignored
        for (int b = 0; b < 4; b++) pw(pa(12, 2, b), "R8");
        // R5: shared mappings
        wmap(4, 60, 6);
        wmap(6, 60, 6);
        wmap(1, 60, 6);
        pw(pa(60, 6, 0), "R5");
        pw(pa(60, 6, 1), "R5");
        // R6: remap in the same cycle as a parameter write
        step(1'b1, 2, mp(40, 1), 1'b1, pa(12, 2, 0), "R6");
        pw(pa(12, 2, 0), "R6");
        pw(pa(40, 1, 0), "R6");
        // R7: set range
        wmap(7, 200, 3);
        pw(pa(200, 3, 0), "R7");
        wmap(7, NSETS - 1, 3);
        pw(pa(NSETS - 1, 3, 0), "R7");
        wmap(5, NSETS, 0);
        pw(pa(NSETS, 0, 0), "R7");
        // R9: idle cycles keep any/idx at zero
        step(1'b0, 0, '0, 1'b0, '0, "R9");
        step(1'b0, 0, '0, 1'b0, '0, "R9");
        rd_check(NCH - 1, mp(NSETS - 1, 3), "R2");
        repeat (3) @(posedge clk);
        #5;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule